// File: doc/BRIEF.md
# Speculative Store Queue with Load Forwarding

This block sits between a core's execution stage and its memory write path. It holds stores that have executed but may still be cancelled. Stores enter in program order. Each store carries a speculation tag that names the branch it depends on. A store leaves for memory only after a commit has cleared its tag. A misprediction clears in one step every buffered store at or after the failing branch, so such a store never reaches memory. Stores that have been committed drain from the oldest end, at most one per cycle, whenever the memory port is ready.

Every store writes one whole aligned line of `LINE_BYTES` bytes. A load of `LOAD_BYTES` bytes can probe the queue in the same cycle and gets one of three answers:
- **forward**: the data comes from the youngest buffered store to the same line.
- **stall**: the load overlaps a buffered store but cannot take its data, because it crosses a `CHUNK_BYTES` sub-chunk boundary or the end of the line.
- **none**: the load overlaps no buffered store.

Top module: `spec_store_buffer`

## Requirements
- R1: While `rst_n` is low the queue is empty: `alloc_ready` is 1, and `mem_valid`, `ld_fwd` and `ld_stall` are 0.
- R2: A store is accepted at a rising edge when `alloc_valid` and `alloc_ready` are both 1. `alloc_ready` is 0 exactly while `DEPTH` stores are held.
- R3: `mem_valid` is 1 only when the oldest held store is committed. `mem_line` and `mem_data` then show that store. It leaves the queue at an edge where `mem_ready` is 1. Stores reach the port in the order they were accepted.
- R4: At an edge with `commit_valid`, every held store whose tag is at most `commit_tag` becomes committed. Tags are compared as unsigned numbers. A store accepted at that same edge is not affected. The change shows on `mem_valid` from the next cycle.
- R5: At an edge with `squash_valid`, every held store that is not committed and has a tag at least `squash_tag` is removed. A commit at the same edge wins over the squash. A store offered at that edge with `alloc_tag` at least `squash_tag` is dropped. Tags of held stores never decrease in program order.
- R6: A removed store never appears on the memory port, and the stores kept keep their order.
- R7: The load line is `ld_addr >> 5` and the line offset is `ld_addr[4:0]`. Byte k of a line is `data[8k+7:8k]`. When `ld_valid` is 1 and the load can forward, `ld_fwd` is 1. `ld_data` then holds the bytes at offset..offset+3 of the youngest held store to that line, taken from state registered before the cycle.
- R8: A load to a held line forwards only if `offset mod 8` is 0 to 4. With 5 to 7 it gets `ld_stall` = 1 instead.
- R9: A load at offset 29 to 31 also overlaps the next line. It stalls if either line is held.
- R10: `ld_fwd` and `ld_stall` are both 0 when `ld_valid` is 0 or when no held store overlaps the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | A new store is offered |
| alloc_line | input | ADDR_W-5 | Line number of the new store |
| alloc_data | input | 256 | Full line data of the new store |
| alloc_tag | input | TAG_W | Speculation tag of the new store |
| alloc_ready | output | 1 | Queue can accept a store |
| commit_valid | input | 1 | Commit request |
| commit_tag | input | TAG_W | Stores with a tag up to this value become committed |
| squash_valid | input | 1 | Misprediction request |
| squash_tag | input | TAG_W | Uncommitted stores with a tag from this value up are removed |
| mem_valid | output | 1 | Oldest store is committed and offered to memory |
| mem_line | output | ADDR_W-5 | Line number of the offered store |
| mem_data | output | 256 | Data of the offered store |
| mem_ready | input | 1 | Memory takes the offered store |
| ld_valid | input | 1 | Load probe present |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_fwd | output | 1 | Load data is forwarded |
| ld_stall | output | 1 | Load overlaps a store it cannot take data from |
| ld_data | output | 32 | Forwarded load bytes, zero otherwise |

## Verification
The bench uses the default parameters: `DEPTH` 8, 32-byte lines, 8-byte chunks, 4-byte loads and 4-bit tags. Stores go only to lines 0 to 3 and loads probe lines 0 to 4. Because of this, repeated stores to one line, loads that cross into the next line, and the full queue are all reached often. Tags rise slowly, so commit and squash boundaries fall in the middle of the queue. Both can also arrive in the same cycle, together with an allocation or a drain.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_FWD   = 2'd1,
        LK_STALL = 2'd2
    } lk_res_e;
endpackage

// File: rtl/ssb_align_rule.sv
module ssb_align_rule #(
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 8,
    parameter int LOAD_BYTES  = 4,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int CH_W  = $clog2(CHUNK_BYTES)
) (
    input  logic [OFF_W-1:0] off,
    output logic             chunk_ok,
    output logic             line_cross
);
    generate
        if (LOAD_BYTES == 1) begin : g_byte
            always_comb begin
                chunk_ok   = 1'b1;
                line_cross = 1'b0;
            end
        end else begin : g_multi
            always_comb begin
                chunk_ok   = (int'(off[CH_W-1:0]) <= CHUNK_BYTES - LOAD_BYTES);
                line_cross = (int'(off) > LINE_BYTES - LOAD_BYTES);
            end
        end
    endgenerate
endmodule

// File: rtl/ssb_fwd_lookup.sv
module ssb_fwd_lookup
    import ssb_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 8,
    parameter int LOAD_BYTES  = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int DATA_W = LINE_BYTES * 8,
    localparam int LD_W   = LOAD_BYTES * 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          ld_valid,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [PTR_W-1:0]              head,
    input  logic [CNT_W-1:0]              count,
    input  logic [DEPTH-1:0][LINE_W-1:0]  ent_line,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output lk_res_e                       res,
    output logic [LD_W-1:0]               ld_data
);
    logic [LINE_W-1:0]           ld_line;
    logic [OFF_W-1:0]            ld_off;
    logic                        chunk_ok;
    logic                        line_cross;
    logic [DEPTH-1:0][PTR_W-1:0] slot_of;
    logic [DEPTH-1:0]            same_hit;
    logic [DEPTH-1:0]            next_hit;
    logic [PTR_W-1:0]            sel_slot;
    logic [DATA_W-1:0]           shifted;

    assign ld_line = ld_addr[ADDR_W-1:OFF_W];
    assign ld_off  = ld_addr[OFF_W-1:0];

    ssb_align_rule #(
        .LINE_BYTES (LINE_BYTES),
        .CHUNK_BYTES(CHUNK_BYTES),
        .LOAD_BYTES (LOAD_BYTES)
    ) u_rule (
        .off       (ld_off),
        .chunk_ok  (chunk_ok),
        .line_cross(line_cross)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign slot_of[i]  = head + PTR_W'(i);
        assign same_hit[i] = (count > CNT_W'(i)) && (ent_line[slot_of[i]] == ld_line);
        assign next_hit[i] = (count > CNT_W'(i)) && line_cross
                             && (ent_line[slot_of[i]] == ld_line + LINE_W'(1));
    end

    always_comb begin
        sel_slot = head;
        for (int i = 0; i < DEPTH; i++) begin
            if (same_hit[i]) sel_slot = slot_of[i];
        end
        shifted = ent_data[sel_slot] >> {ld_off, 3'b000};
        if (!ld_valid || (same_hit == '0 && next_hit == '0)) begin
            res = LK_NONE;
        end else if (chunk_ok && !line_cross) begin
            res = LK_FWD;
        end else begin
            res = LK_STALL;
        end
        ld_data = (res == LK_FWD) ? shifted[LD_W-1:0] : '0;
    end
endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer
    import ssb_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 4,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 8,
    parameter int LOAD_BYTES  = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int CH_W   = $clog2(CHUNK_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int DATA_W = LINE_BYTES * 8,
    localparam int LD_W   = LOAD_BYTES * 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    input  logic              commit_valid,
    input  logic [TAG_W-1:0]  commit_tag,
    input  logic              squash_valid,
    input  logic [TAG_W-1:0]  squash_tag,
    output logic              mem_valid,
    output logic [LINE_W-1:0] mem_line,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_fwd,
    output logic              ld_stall,
    output logic [LD_W-1:0]   ld_data
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic              cmt;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  ent;
        logic [PTR_W-1:0]  head;
        logic [CNT_W-1:0]  count;
    } state_t;

    state_t st_d, st_q;

    logic                        full;
    logic                        pop;
    logic                        accept;
    logic                        found;
    logic [CNT_W-1:0]            cut;
    logic [PTR_W-1:0]            slot;
    logic [PTR_W-1:0]            wr_slot;
    logic [DEPTH-1:0][LINE_W-1:0] ent_line;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    lk_res_e                     lk_res;

    assign full        = (st_q.count == CNT_W'(DEPTH));
    assign alloc_ready = !full;
    assign mem_valid   = (st_q.count != '0) && st_q.ent[st_q.head].cmt;
    assign mem_line    = st_q.ent[st_q.head].line;
    assign mem_data    = st_q.ent[st_q.head].data;
    assign pop         = mem_valid && mem_ready;
    assign accept      = alloc_valid && !full && !(squash_valid && alloc_tag >= squash_tag);

    // Next-state computation: commit, then squash cut, then drain and allocation.
    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        cut   = st_q.count;
        slot  = st_q.head;
        for (int i = 0; i < DEPTH; i++) begin
            slot = st_q.head + PTR_W'(i);
            if (commit_valid && CNT_W'(i) < st_q.count && st_q.ent[slot].tag <= commit_tag) begin
                st_d.ent[slot].cmt = 1'b1;
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            slot = st_q.head + PTR_W'(i);
            if (squash_valid && !found && CNT_W'(i) < st_q.count
                && !st_d.ent[slot].cmt && st_q.ent[slot].tag >= squash_tag) begin
                found = 1'b1;
                cut   = CNT_W'(i);
            end
        end
        wr_slot = st_q.head + PTR_W'(cut);
        if (accept) begin
            st_d.ent[wr_slot].line = alloc_line;
            st_d.ent[wr_slot].data = alloc_data;
            st_d.ent[wr_slot].tag  = alloc_tag;
            st_d.ent[wr_slot].cmt  = 1'b0;
        end
        st_d.count = cut - CNT_W'(pop) + CNT_W'(accept);
        if (pop) st_d.head = st_q.head + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_flat
        assign ent_line[s] = st_q.ent[s].line;
        assign ent_data[s] = st_q.ent[s].data;
    end

    ssb_fwd_lookup #(
        .DEPTH      (DEPTH),
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .CHUNK_BYTES(CHUNK_BYTES),
        .LOAD_BYTES (LOAD_BYTES)
    ) u_lookup (
        .ld_valid(ld_valid),
        .ld_addr (ld_addr),
        .head    (st_q.head),
        .count   (st_q.count),
        .ent_line(ent_line),
        .ent_data(ent_data),
        .res     (lk_res),
        .ld_data (ld_data)
    );

    assign ld_fwd   = (lk_res == LK_FWD);
    assign ld_stall = (lk_res == LK_STALL);

    assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ready |=> st_q.count <= $past(st_q.count));

    assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_line) && $stable(mem_data));

    assert_squash_no_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid && !(alloc_valid && alloc_tag < squash_tag) |=> st_q.count <= $past(st_q.count));

    assert_fwd_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> st_q.count != '0);

    assert_fwd_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> int'(ld_addr[CH_W-1:0]) <= CHUNK_BYTES - LOAD_BYTES);

    assert_idle_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_fwd && !ld_stall);
endmodule

// File: tb/spec_store_buffer_test.sv
module spec_store_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alloc_valid = 1'b0;
    logic [26:0]  alloc_line = '0;
    logic [255:0] alloc_data = '0;
    logic [3:0]   alloc_tag = '0;
    logic         alloc_ready;
    logic         commit_valid = 1'b0;
    logic [3:0]   commit_tag = '0;
    logic         squash_valid = 1'b0;
    logic [3:0]   squash_tag = '0;
    logic         mem_valid;
    logic [26:0]  mem_line;
    logic [255:0] mem_data;
    logic         mem_ready = 1'b0;
    logic         ld_valid = 1'b0;
    logic [31:0]  ld_addr = '0;
    logic         ld_fwd;
    logic         ld_stall;
    logic [31:0]  ld_data;

    int compared = 0;
    int mismatched = 0;
    int cur_tag = 0;

    typedef struct {
        logic [26:0]  line;
        logic [255:0] data;
        int           tag;
        bit           cmt;
    } mentry_t;
    mentry_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_store_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_line(alloc_line), .alloc_data(alloc_data),
        .alloc_tag(alloc_tag), .alloc_ready(alloc_ready),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .squash_valid(squash_valid), .squash_tag(squash_tag),
        .mem_valid(mem_valid), .mem_line(mem_line), .mem_data(mem_data), .mem_ready(mem_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_fwd(ld_fwd), .ld_stall(ld_stall), .ld_data(ld_data)
    );

    task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compares all outputs against the queue model, then advances the model by one edge.
    task automatic step();
        int  line_l, off, same_idx;
        bit  overlap, e_fwd, e_stall, e_mv, pop, acc;
        logic [255:0] sh;
        int  cut;
        #1;
        line_l = int'(ld_addr >> 5);
        off = int'(ld_addr % 32);
        overlap = 0;
        same_idx = -1;
        foreach (q[i]) begin
            if (int'(q[i].line) == line_l) begin overlap = 1; same_idx = i; end
            else if (off > 28 && int'(q[i].line) == line_l + 1) overlap = 1;
        end
        e_fwd = 0; e_stall = 0;
        if (ld_valid && overlap) begin
            if ((off % 8) <= 4) e_fwd = 1; else e_stall = 1;
        end
        e_mv = (q.size() > 0) && q[0].cmt;
        chk("R2 R5", "alloc_ready", {255'b0, alloc_ready}, {255'b0, (q.size() < DEPTH)});
        chk("R3 R4", "mem_valid", {255'b0, mem_valid}, {255'b0, e_mv});
        if (e_mv) begin
            chk("R3 R6", "mem_line", {229'b0, mem_line}, {229'b0, q[0].line});
            chk("R3 R6", "mem_data", mem_data, q[0].data);
        end
        chk("R7 R10", "ld_fwd", {255'b0, ld_fwd}, {255'b0, e_fwd});
        chk("R8 R9 R10", "ld_stall", {255'b0, ld_stall}, {255'b0, e_stall});
        if (e_fwd) begin
            sh = q[same_idx].data >> (off * 8);
            chk("R7", "ld_data", {224'b0, ld_data}, {224'b0, sh[31:0]});
        end
        pop = e_mv && mem_ready;
        acc = alloc_valid && (q.size() < DEPTH) && !(squash_valid && int'(alloc_tag) >= int'(squash_tag));
        if (commit_valid) foreach (q[i]) if (q[i].tag <= int'(commit_tag)) q[i].cmt = 1;
        if (squash_valid) begin
            cut = q.size();
            for (int i = q.size() - 1; i >= 0; i--)
                if (!q[i].cmt && q[i].tag >= int'(squash_tag)) cut = i;
            while (q.size() > cut) void'(q.pop_back());
        end
        if (pop) void'(q.pop_front());
        if (acc) q.push_back('{line: alloc_line, data: alloc_data, tag: int'(alloc_tag), cmt: 0});
        @(negedge clk);
    endtask

    function automatic logic [255:0] rand_line_data();
        logic [255:0] d;
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = $urandom;
        return d;
    endfunction

    task automatic drive(int p_alloc, int p_commit, int p_squash, int p_ready);
        if (q.size() == 0) cur_tag = 0;
        if (($urandom % 4) == 0 && cur_tag < 15) cur_tag++;
        alloc_valid  = (($urandom % 100) < p_alloc);
        alloc_line   = 27'($urandom % 4);
        alloc_data   = rand_line_data();
        alloc_tag    = 4'(cur_tag);
        commit_valid = (($urandom % 100) < p_commit);
        commit_tag   = 4'($urandom % (cur_tag + 1));
        squash_valid = (($urandom % 100) < p_squash);
        squash_tag   = 4'($urandom % (cur_tag + 1));
        mem_ready    = (($urandom % 100) < p_ready);
        ld_valid     = (($urandom % 10) != 0);
        ld_addr      = (($urandom % 5) << 5) | ($urandom % 32);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        ld_valid = 1'b1;
        alloc_valid = 1'b1;
        ld_addr = 32'h0;
        #1;
        // R1: reset state
        chk("R1", "alloc_ready", {255'b0, alloc_ready}, {255'b0, 1'b1});
        chk("R1", "mem_valid", {255'b0, mem_valid}, 256'b0);
        chk("R1", "ld_fwd", {255'b0, ld_fwd}, 256'b0);
        chk("R1", "ld_stall", {255'b0, ld_stall}, 256'b0);
        @(negedge clk);
        alloc_valid = 1'b0;
        rst_n = 1'b1;
        // Fill to full with nothing committed (R2, R7, R8, R9)
        for (int c = 0; c < 14; c++) begin
            drive(100, 0, 0, 100);
            step();
        end
        // Commit and drain with a stalling memory (R3, R4)
        for (int c = 0; c < 30; c++) begin
            drive(20, 40, 0, 50);
            step();
        end
        // Squash-heavy phase (R5, R6)
        for (int c = 0; c < 200; c++) begin
            drive(70, 20, 25, 60);
            step();
        end
        // Mixed random traffic
        for (int c = 0; c < 5000; c++) begin
            drive(60, 25, 6, 70);
            step();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule